// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the arithmetic and logic stage of a small accumulator-style datapath. Each cycle it takes an operation code, two 8-bit operands and the current flag vector. One cycle later it presents the 8-bit result, the new flag vector, a mask of the flags the operation touched, and a write strobe. The write strobe tells the surrounding datapath whether the result should be stored.

The operation set covers several groups:
- binary add and subtract, each with and without carry or borrow
- a compare that only sets flags
- the bitwise operations
- complement, negate, increment and decrement
- left and right shifts, and rotates through the carry
- a decimal correction that turns the binary sum of two packed BCD bytes into a valid BCD byte.

Flags outside the operation's mask pass through from the incoming flag vector. Multi-byte sums, bit counting and BCD arithmetic are therefore built by feeding `flags_o` back into `flags_i`.

Top module: `alu8_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs become zero (`res_o`, `flags_o`, `upd_o` all 0, `wr_o` 0).
- R2: Outputs reflect the inputs sampled at the previous rising edge. Flag vectors are ordered bit 4 H, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 negate, 10 increment, 11 decrement, 12 shift left, 13 arithmetic shift right, 14 logical shift right, 15 rotate left, 16 rotate right, 17 decimal adjust. Codes 18 to 31 return `a_i` unchanged, with `upd_o` = 0 and `wr_o` = 0.
- R3: Add and add-with-carry compute a+b (+C). C is the carry out of bit 7 and H is the carry out of bit 3. V is set when two operands of equal sign give a result of the other sign. All five flags are updated.
- R4: Subtract and subtract-with-borrow compute a−b (−C). C is set on an unsigned borrow. V is set when a positive minus a negative gives a negative, or a negative minus a positive gives a positive. N, Z, V and C are updated; H is not.
- R5: Compare sets N, Z, V and C exactly as subtract does, with `wr_o` = 0. Z = 1 exactly when the operands are equal.
- R6: AND, OR and XOR update N, Z and V, with V cleared. C and H keep their incoming values.
- R7: Complement gives ~a, clears V and sets C. Negate gives 0−a, sets C unless the result is zero, and sets V only for a = 0x80. Both update N, Z, V and C.
- R8: Increment and decrement update N, Z and V only. V is set for 0x7F+1 and for 0x80−1. C keeps its incoming value.
- R9: Shifts move the bit shifted out into C. Shift left fills bit 0 with 0. Arithmetic shift right keeps bit 7. Logical shift right fills bit 7 with 0. For every shift and rotate, V = N xor C.
- R10: Rotate left puts the incoming C into bit 0 and bit 7 into C. Rotate right puts the incoming C into bit 7 and bit 0 into C.
- R11: Decimal adjust corrects `a_i` using the incoming H and C:
  - It adds 0x06 when the low nibble exceeds 9 or H is set.
  - It adds 0x60 when `a_i` exceeds 0x99 or C is set, and in that case it sets C.
  - It updates N, Z and C.
- R12: Every flag whose `upd_o` bit is 0 equals the corresponding bit of `flags_i` from the sampled cycle.
- R13: Whenever N or Z is updated, N equals bit 7 of `res_o` and Z is set exactly when `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (sole operand of unary operations) |
| b_i | input | 8 | Second operand |
| flags_i | input | 5 | Incoming flags {H,N,Z,V,C} |
| res_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered flags after merge with incoming flags |
| upd_o | output | 5 | Mask of flags written by the operation |
| wr_o | output | 1 | Result should be stored |

## Verification
The block holds no state apart from its output register, so any defect shows at the ports one cycle after the operation that exposes it. A wrong adder or a wrong borrow polarity surfaces as a bad C or V on the very next sample. A wrong update mask shows up as a flag that fails to follow `flags_i`. Chained sequences check that the flags are usable across operations: a multi-byte add, a shift-and-add bit count and BCD addition with correction. In these sequences a flag error in one step corrupts every later step.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NF = 5;
  localparam int OPW = 5;
  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FH = 4;
  localparam logic [NF-1:0] M_ALL  = 5'b11111;
  localparam logic [NF-1:0] M_NZVC = 5'b01111;
  localparam logic [NF-1:0] M_NZV  = 5'b01110;
  localparam logic [NF-1:0] M_NZC  = 5'b01101;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_COM = 5'd8,  OP_NEG = 5'd9,  OP_INC = 5'd10, OP_DEC = 5'd11,
    OP_ASL = 5'd12, OP_ASR = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR = 5'd16, OP_DAA = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic [NF-1:0] flg;
    logic [NF-1:0] upd;
    logic          wr;
  } alu_out_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  output alu_out_t       o
);
  logic [DW-1:0] ax, bx, bb;
  logic          sub, ci, c0;
  logic [DW:0]   full;

  always_comb begin
    ax  = a;
    bx  = b;
    sub = 1'b0;
    ci  = 1'b0;
    case (op)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = cin; end
      OP_NEG: begin sub = 1'b1; ax = '0; bx = a; end
      OP_INC: bx = DW'(1);
      OP_DEC: begin sub = 1'b1; bx = DW'(1); end
      default: ;
    endcase
    bb   = sub ? ~bx : bx;
    c0   = sub ? ~ci : ci;
    full = {1'b0, ax} + {1'b0, bb} + {{DW{1'b0}}, c0};
  end

  always_comb begin
    o         = '0;
    o.res     = full[DW-1:0];
    o.wr      = 1'b1;
    o.flg[FN] = full[DW-1];
    o.flg[FZ] = (full[DW-1:0] == '0);
    o.flg[FV] = (ax[DW-1] == bb[DW-1]) && (full[DW-1] != ax[DW-1]);
    o.flg[FH] = ax[4] ^ bb[4] ^ full[4];
    o.flg[FC] = sub ? ~full[DW] : full[DW];
    case (op)
      OP_ADD, OP_ADC:                 o.upd = M_ALL;
      OP_SUB, OP_SBC, OP_NEG:         o.upd = M_NZVC;
      OP_CMP: begin o.upd = M_NZVC; o.wr = 1'b0; end
      OP_INC, OP_DEC:                 o.upd = M_NZV;
      default: begin o.upd = '0; o.wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  output alu_out_t       o
);
  logic [DW-1:0] r;
  logic          co, fill, is_shift;

  always_comb begin
    r        = a;
    co       = cin;
    is_shift = 1'b0;
    fill     = 1'b0;
    case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_COM: begin r = ~a; co = 1'b1; end
      OP_ASL, OP_ROL: begin
        is_shift = 1'b1;
        co       = a[DW-1];
        r        = {a[DW-2:0], (op == OP_ROL) ? cin : 1'b0};
      end
      OP_ASR, OP_LSR, OP_ROR: begin
        is_shift = 1'b1;
        co       = a[0];
        if (op == OP_ASR)      fill = a[DW-1];
        else if (op == OP_ROR) fill = cin;
        r = {fill, a[DW-1:1]};
      end
      default: ;
    endcase
  end

  always_comb begin
    o         = '0;
    o.res     = r;
    o.wr      = 1'b1;
    o.flg[FN] = r[DW-1];
    o.flg[FZ] = (r == '0);
    o.flg[FC] = co;
    o.flg[FV] = is_shift ? (r[DW-1] ^ co) : 1'b0;
    case (op)
      OP_AND, OP_OR, OP_XOR: o.upd = M_NZV;
      OP_COM, OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: o.upd = M_NZVC;
      default: begin o.upd = '0; o.wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
  import alu8_pkg::*;
#(
  parameter int DIGIT_MAX = 9
) (
  input  logic [DW-1:0] a,
  input  logic          hin,
  input  logic          cin,
  output alu_out_t      o
);
  localparam logic [DW-1:0] PAIR_MAX = DW'(DIGIT_MAX * 16 + DIGIT_MAX);
  localparam logic [3:0]    FIX      = 4'(15 - DIGIT_MAX);

  logic          lo_fix, hi_fix;
  logic [DW-1:0] adj, r;

  always_comb begin
    lo_fix    = (a[3:0] > 4'(DIGIT_MAX)) || hin;
    hi_fix    = (a > PAIR_MAX) || cin;
    adj       = {hi_fix ? FIX : 4'h0, lo_fix ? FIX : 4'h0};
    r         = a + adj;
    o         = '0;
    o.res     = r;
    o.wr      = 1'b1;
    o.upd     = M_NZC;
    o.flg[FN] = r[DW-1];
    o.flg[FZ] = (r == '0);
    o.flg[FC] = hi_fix;
  end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [NF-1:0]  flags_i,
  output logic [DW-1:0]  res_o,
  output logic [NF-1:0]  flags_o,
  output logic [NF-1:0]  upd_o,
  output logic           wr_o
);
  alu_out_t o_ar, o_bt, o_bcd, sel;

  alu8_arith u_arith (.op(op_i), .a(a_i), .b(b_i), .cin(flags_i[FC]), .o(o_ar));
  alu8_bitops u_bitops (.op(op_i), .a(a_i), .b(b_i), .cin(flags_i[FC]), .o(o_bt));
  alu8_bcd #(.DIGIT_MAX(9)) u_bcd (.a(a_i), .hin(flags_i[FH]), .cin(flags_i[FC]), .o(o_bcd));

  always_comb begin
    sel = '0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG, OP_INC, OP_DEC: sel = o_ar;
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: sel = o_bt;
      OP_DAA: sel = o_bcd;
      default: begin sel.res = a_i; sel.upd = '0; sel.wr = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      upd_o   <= '0;
      wr_o    <= 1'b0;
    end else begin
      res_o   <= sel.res;
      flags_o <= (sel.flg & sel.upd) | (flags_i & ~sel.upd);
      upd_o   <= sel.upd;
      wr_o    <= sel.wr;
    end
  end
endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  a_i,
  input logic [DW-1:0]  b_i,
  input logic [NF-1:0]  flags_i,
  input logic [DW-1:0]  res_o,
  input logic [NF-1:0]  flags_o,
  input logic [NF-1:0]  upd_o,
  input logic           wr_o
);
  logic past_ok = 1'b0;
  logic rst_q   = 1'b0;
  always_ff @(posedge clk) begin
    past_ok <= !rst;
    rst_q   <= rst;
  end

  // R1
  always @(posedge clk) begin
    if (rst_q) begin
      rst_clear_chk: assert (res_o == '0 && flags_o == '0 && upd_o == '0 && !wr_o)
        else $error("reset state not cleared");
    end
  end

  // R13
  nz_match_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && upd_o[FZ] |-> (flags_o[FZ] == (res_o == '0)) && (flags_o[FN] == res_o[DW-1]));

  // R12
  keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((flags_o ^ $past(flags_i)) & ~upd_o) == '0);

  // R5
  cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) == OP_CMP |-> !wr_o && (flags_o[FZ] == ($past(a_i) == $past(b_i))));

  // R6
  logic_v_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR)
      |-> !flags_o[FV] && !upd_o[FC] && !upd_o[FH]);

  // R9
  shift_v_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) >= OP_ASL && $past(op_i) <= OP_ROR
      |-> flags_o[FV] == (flags_o[FN] ^ flags_o[FC]));

  // R2
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) > OP_DAA |-> res_o == $past(a_i) && upd_o == '0 && !wr_o);
endmodule

bind alu8_unit alu8_unit_chk u_chk (.*);

// File: tb/tb_alu8_unit.sv
module tb_alu8_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [4:0] flags_i = '0;
  logic [7:0] res_o;
  logic [4:0] flags_o, upd_o;
  logic       wr_o;
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  alu8_unit dut (.clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
                 .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o),
                 .upd_o(upd_o), .wr_o(wr_o));

  function automatic int sg(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // returns {wr, upd[4:0], flags[4:0], res[7:0]}
  function automatic logic [18:0] model(int op, int a, int b, logic [4:0] f);
    int r = a, s, sv, c = int'(f[0]), adj;
    logic h = 0, n, z, v = 0, cy = f[0], wr = 1;
    logic [4:0] u = 5'b00000, nf, fo;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? c : 0); r = s % 256; cy = s > 255;
        h = (a % 16 + b % 16 + ((op == 1) ? c : 0)) > 15;
        sv = sg(a) + sg(b) + ((op == 1) ? c : 0); v = sv > 127 || sv < -128; u = 5'b11111;
      end
      2, 3, 4: begin
        s = a - b - ((op == 3) ? c : 0); cy = s < 0; r = (s + 512) % 256;
        sv = sg(a) - sg(b) - ((op == 3) ? c : 0); v = sv > 127 || sv < -128;
        u = 5'b01111; wr = (op != 4);
      end
      5: begin r = a & b; u = 5'b01110; end
      6: begin r = a | b; u = 5'b01110; end
      7: begin r = a ^ b; u = 5'b01110; end
      8: begin r = 255 - a; cy = 1; u = 5'b01111; end
      9: begin r = (256 - a) % 256; cy = a != 0; v = a == 128; u = 5'b01111; end
      10: begin r = (a + 1) % 256; v = a == 127; u = 5'b01110; end
      11: begin r = (a + 255) % 256; v = a == 128; u = 5'b01110; end
      12, 13, 14, 15, 16: begin
        case (op)
          12: begin r = (a * 2) % 256; cy = a >= 128; end
          13: begin r = a / 2 + ((a >= 128) ? 128 : 0); cy = a % 2; end
          14: begin r = a / 2; cy = a % 2; end
          15: begin r = (a * 2) % 256 + c; cy = a >= 128; end
          default: begin r = a / 2 + c * 128; cy = a % 2; end
        endcase
        v = (r >= 128) ^ cy; u = 5'b01111;
      end
      17: begin
        adj = 0;
        if ((a % 16) > 9 || f[4]) adj += 6;
        cy = 0;
        if (a > 153 || f[0]) begin adj += 96; cy = 1; end
        r = (a + adj) % 256; u = 5'b01101;
      end
      default: begin r = a; wr = 0; end
    endcase
    n = r >= 128; z = r == 0;
    nf = {h, n, z, v, cy};
    for (int k = 0; k < 5; k++) fo[k] = u[k] ? nf[k] : f[k];
    return {wr, u, fo, 8'(r)};
  endfunction

  function automatic string req_of(int op);
    case (op)
      0, 1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5, 6, 7: return "R6";
      8, 9: return "R7";
      10, 11: return "R8";
      12, 13, 14: return "R9";
      15, 16: return "R10";
      17: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input logic [4:0] f,
                      output logic [7:0] r, output logic [4:0] fo);
    logic [18:0] e;
    @(negedge clk);
    op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); flags_i = f;
    e = model(op, a, b, f);
    @(negedge clk);
    check(req_of(op), {13'd0, wr_o, upd_o, flags_o, res_o}, {13'd0, e});
    r = res_o; fo = flags_o;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, acc;
    logic [4:0] fo;
    // R1: reset with busy inputs
    op_i = 5'd0; a_i = 8'hFF; b_i = 8'h01; flags_i = 5'h1F;
    repeat (3) @(negedge clk);
    check("R1", {res_o, flags_o, upd_o, 3'b0, wr_o}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R3 corner cases
    step(0, 8'h7F, 8'h01, 5'h00, r, fo);
    step(0, 8'h80, 8'h80, 5'h00, r, fo);
    step(1, 8'h0F, 8'h00, 5'h01, r, fo);
    step(1, 8'hFF, 8'h00, 5'h01, r, fo);
    // R4 / R5
    step(2, 8'h00, 8'h01, 5'h00, r, fo);
    step(2, 8'h80, 8'h01, 5'h00, r, fo);
    step(3, 8'h05, 8'h05, 5'h01, r, fo);
    step(4, 8'h42, 8'h42, 5'h10, r, fo);
    step(4, 8'h10, 8'h42, 5'h00, r, fo);
    // R6, R7, R8
    step(5, 8'hF0, 8'h0F, 5'h13, r, fo);
    step(7, 8'hAA, 8'h55, 5'h02, r, fo);
    step(8, 8'h00, 8'h00, 5'h00, r, fo);
    step(9, 8'h80, 8'h00, 5'h00, r, fo);
    step(9, 8'h00, 8'h00, 5'h01, r, fo);
    step(10, 8'h7F, 8'h00, 5'h01, r, fo);
    step(11, 8'h80, 8'h00, 5'h00, r, fo);
    // R9, R10
    step(13, 8'h81, 8'h00, 5'h00, r, fo);
    step(15, 8'h80, 8'h00, 5'h01, r, fo);
    step(16, 8'h01, 8'h00, 5'h01, r, fo);
    // R2 undefined codes
    step(18, 8'h5A, 8'h00, 5'h15, r, fo);
    step(31, 8'hC3, 8'h11, 5'h0A, r, fo);

    // R3 multi-byte chain: 0x00CC + 0x3276 = 0x3342
    step(0, 8'hCC, 8'h76, 5'h00, r, fo);
    check("R3 low byte", {24'd0, r}, 32'h42);
    step(1, 8'h00, 8'h32, fo, r, fo);
    check("R3 high byte", {24'd0, r}, 32'h33);

    // R9 bit count via shift and add-with-carry
    acc = 8'h00; r = 8'hB5; fo = 5'h00;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] nr, na;
      logic [4:0] f1, f2;
      step(12, r, 0, fo, nr, f1);
      step(1, acc, 0, f1, na, f2);
      r = nr; acc = na; fo = f2;
    end
    check("R9 bit count", {24'd0, acc}, 32'd5);

    // R11 BCD: 38+45 -> 83 ; 99+01 -> 00 with carry
    step(0, 8'h38, 8'h45, 5'h00, r, fo);
    step(17, r, 0, fo, r, fo);
    check("R11 bcd 83", {24'd0, r}, 32'h83);
    step(0, 8'h99, 8'h01, 5'h00, r, fo);
    step(17, r, 0, fo, r, fo);
    check("R11 bcd carry", {23'd0, fo[0], r}, 32'h100);
    step(17, 8'h09, 0, 5'h10, r, fo);

    // R12 R13 random coverage
    for (int i = 0; i < 600; i++)
      step(int'($urandom_range(0, 21)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), 5'($urandom_range(0, 31)), r, fo);

    // R1 reset again mid-stream
    @(negedge clk); rst = 1'b1; op_i = 5'd0; a_i = 8'hFF; b_i = 8'hFF;
    @(negedge clk);
    check("R1 second reset", {res_o, flags_o, upd_o, 3'b0, wr_o}, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule